// File: doc/BRIEF.md
# Machine-Mode Trap and Return Controller

This block owns the trap state of a core that runs only at the machine privilege level. When the pipeline signals an exception or an interrupt, the block saves the return address, the cause and a trap value, pushes the global interrupt enable onto a one-deep stack, and returns the handler address at once. The handler address comes from the trap-vector register, in either direct or vectored mode. A return strobe pops the enable stack and sends the core back to the saved return address.

The block also decides which interrupt to raise. It compares the three interrupt lines (software, timer and external) against the enable register and the global enable. It then presents the lowest-numbered eligible line to the pipeline as a registered request. The pipeline converts that request into a trap. Software reaches the seven trap registers through a single-cycle CSR port that uses the standard machine CSR addresses.

Top module: `m_trap_ctrl`

## Requirements
- R1: After reset, mstatus reads 0x1800, and mie, mtvec, mepc, mcause and mtval read 0. redirect_o and irq_req_o are 0.
- R2: In mstatus (0x300), only bit 3 (global enable) and bit 7 (saved enable) are writable. Bits 12:11 always read 1. All other bits read 0.
- R3: In mie (0x304), only bits 3, 7 and 11 are stored. mip (0x344) reads irq_sw_i, irq_tim_i and irq_ext_i at bits 3, 7 and 11, and writes to mip have no effect.
- R4: On trap entry, the saved enable takes the old global enable, and the global enable clears. On a return with no trap in the same cycle, the global enable takes the saved enable, and the saved enable becomes 1. A trap takes priority over a return in the same cycle.
- R5: On trap entry, mcause (0x342) is written with the interrupt flag at bit XLEN-1 and the cause code in the low bits. An environment call stays cause 11. Reads and writes of mcause keep only bit XLEN-1 and the low log2(NUM_IRQ) bits.
- R6: On trap entry, mepc (0x341) takes trap_pc_i for an exception and trap_npc_i for an interrupt. Every value written to mepc has bit 0 cleared.
- R7: On an exception, mtval (0x343) is loaded according to the cause. Cause 0 loads trap_tval_i. Cause 2 loads trap_tval_i, but only its low 16 bits when the low two bits are not 3. Cause 3 loads trap_pc_i. Causes 4 and 6 load trap_addr_i. Every other cause loads 0. An interrupt leaves mtval unchanged.
- R8: While trap_valid_i is high, redirect_o is 1 in the same cycle, and redirect_pc_o is mtvec with bits 1:0 cleared. If mtvec bit 0 is 1 and the trap is an interrupt, 4 × cause is added.
- R9: When mret_i is high and trap_valid_i is low, redirect_o is 1 and redirect_pc_o equals the current mepc.
- R10: One cycle after the block's state and lines allow it, irq_req_o rises. A line is eligible when it is pending and enabled, and also either priv_i is not 3 or the global enable is set. irq_cause_o then gives the lowest eligible bit index. irq_req_o is 0 in the cycle after a trap entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege level (3 = machine) |
| trap_valid_i | input | 1 | Trap entry request |
| trap_irq_i | input | 1 | Request is an interrupt |
| trap_cause_i | input | CAUSE_W | Exception or interrupt code |
| trap_pc_i | input | XLEN | Address of the faulting instruction |
| trap_npc_i | input | XLEN | Address of the next instruction |
| trap_tval_i | input | XLEN | Supplied trap value or instruction bits |
| trap_addr_i | input | XLEN | Faulting data address |
| mret_i | input | 1 | Trap return strobe |
| irq_sw_i | input | 1 | Software interrupt line |
| irq_tim_i | input | 1 | Timer interrupt line |
| irq_ext_i | input | 1 | External interrupt line |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| redirect_o | output | 1 | Fetch redirect valid |
| redirect_pc_o | output | XLEN | Fetch redirect target |
| irq_req_o | output | 1 | Eligible interrupt present |
| irq_cause_o | output | CAUSE_W | Code of the selected interrupt |

## Verification
The stimulus mixes random CSR writes full of ones, random interrupt-line patterns, and random mixes of exception causes and interrupt causes. Together these separate the writable bits from the fixed bits, and the per-cause trap-value choice from a plain copy. Traps are taken with random trap-vector values in both modes, so that an added vector offset shows up only on interrupts with the mode bit set. Directed cases cover several situations. One case has all three lines pending to test the ordering. Another drives priv_i below machine with the global enable clear to test eligibility. The last case issues a trap and a return in the same cycle to show which one wins.

// File: rtl/m_trap_pkg.sv
package m_trap_pkg;
  localparam logic [11:0] CSR_MSTATUS = 12'h300;
  localparam logic [11:0] CSR_MIE     = 12'h304;
  localparam logic [11:0] CSR_MTVEC   = 12'h305;
  localparam logic [11:0] CSR_MEPC    = 12'h341;
  localparam logic [11:0] CSR_MCAUSE  = 12'h342;
  localparam logic [11:0] CSR_MTVAL   = 12'h343;
  localparam logic [11:0] CSR_MIP     = 12'h344;

  localparam int BIT_SW  = 3;
  localparam int BIT_TIM = 7;
  localparam int BIT_EXT = 11;
  localparam int BIT_GIE = 3;
  localparam int BIT_SIE = 7;

  localparam int EXC_FETCH_MIS = 0;
  localparam int EXC_ILLEGAL   = 2;
  localparam int EXC_BREAK     = 3;
  localparam int EXC_LOAD_MIS  = 4;
  localparam int EXC_STORE_MIS = 6;
endpackage

// File: rtl/m_trap_irq_sel.sv
module m_trap_irq_sel #(
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pend_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic             glob_en_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [WIDTH-1:0] act;
  logic [WIDTH-1:0] grant;

  assign act = glob_en_i ? (pend_i & en_i) : '0;

  // scan downward so the lowest set bit is the last to overwrite
  always_comb begin
    idx_o = '0;
    grant = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (act[i]) begin
        idx_o = IDX_W'(i);
        grant = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign valid_o = |act;

  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (valid_o == (grant != '0)));
  // R10
  sel_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && en_i[idx_o] && glob_en_i));
endmodule

// File: rtl/m_trap_tval.sv
module m_trap_tval #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4,
  parameter bit HAS_C   = 1'b1
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    tval_i,
  input  logic [XLEN-1:0]    addr_i,
  output logic [XLEN-1:0]    tval_o
);
  import m_trap_pkg::*;

  logic is_short;
  assign is_short = HAS_C && (tval_i[1:0] != 2'b11);

  always_comb begin
    unique case (int'(cause_i))
      EXC_FETCH_MIS:               tval_o = tval_i;
      EXC_ILLEGAL:                 tval_o = is_short ? {{(XLEN-16){1'b0}}, tval_i[15:0]} : tval_i;
      EXC_BREAK:                   tval_o = pc_i;
      EXC_LOAD_MIS, EXC_STORE_MIS: tval_o = addr_i;
      default:                     tval_o = '0;
    endcase
  end
endmodule

// File: rtl/m_trap_ctrl.sv
module m_trap_ctrl #(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 16,
  parameter bit HAS_C   = 1'b1,
  localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         priv_i,
  input  logic               trap_valid_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic [XLEN-1:0]    trap_npc_i,
  input  logic [XLEN-1:0]    trap_tval_i,
  input  logic [XLEN-1:0]    trap_addr_i,
  input  logic               mret_i,
  input  logic               irq_sw_i,
  input  logic               irq_tim_i,
  input  logic               irq_ext_i,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               irq_req_o,
  output logic [CAUSE_W-1:0] irq_cause_o
);
  import m_trap_pkg::*;

  localparam int IDX_W = $clog2(XLEN);
  localparam logic [XLEN-1:0] PC_MASK = HAS_C ? ~XLEN'(1) : ~XLEN'(3);
  localparam logic [XLEN-1:0] CAUSE_MASK = {1'b1, {(XLEN-1-CAUSE_W){1'b0}}, {CAUSE_W{1'b1}}};
  localparam logic [XLEN-1:0] IE_MASK = XLEN'((1 << BIT_SW) | (1 << BIT_TIM) | (1 << BIT_EXT));

  logic              gie_q, sie_q;
  logic [XLEN-1:0]   mie_q, mtvec_q, mepc_q, mcause_q, mtval_q;
  logic [XLEN-1:0]   mip_vec, mstatus_rd, tval_sel, vec_off;
  logic              wr_ok, sel_valid;
  logic [IDX_W-1:0]  sel_idx;

  always_comb begin
    mip_vec = '0;
    mip_vec[BIT_SW]  = irq_sw_i;
    mip_vec[BIT_TIM] = irq_tim_i;
    mip_vec[BIT_EXT] = irq_ext_i;
  end

  always_comb begin
    mstatus_rd = '0;
    mstatus_rd[12:11] = 2'b11;
    mstatus_rd[BIT_GIE] = gie_q;
    mstatus_rd[BIT_SIE] = sie_q;
  end

  m_trap_tval #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_C(HAS_C)) i_tval (
    .cause_i (trap_cause_i),
    .pc_i    (trap_pc_i),
    .tval_i  (trap_tval_i),
    .addr_i  (trap_addr_i),
    .tval_o  (tval_sel)
  );

  m_trap_irq_sel #(.WIDTH(XLEN)) i_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (mip_vec),
    .en_i      (mie_q),
    .glob_en_i ((priv_i != 2'b11) || gie_q),
    .valid_o   (sel_valid),
    .idx_o     (sel_idx)
  );

  assign wr_ok = csr_we_i && !trap_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q    <= 1'b0;
      sie_q    <= 1'b0;
      mie_q    <= '0;
      mtvec_q  <= '0;
      mepc_q   <= '0;
      mcause_q <= '0;
      mtval_q  <= '0;
    end else if (trap_valid_i) begin
      sie_q    <= gie_q;
      gie_q    <= 1'b0;
      mepc_q   <= (trap_irq_i ? trap_npc_i : trap_pc_i) & PC_MASK;
      mcause_q <= {trap_irq_i, {(XLEN-1-CAUSE_W){1'b0}}, trap_cause_i};
      if (!trap_irq_i) mtval_q <= tval_sel;
    end else begin
      if (mret_i) begin
        gie_q <= sie_q;
        sie_q <= 1'b1;
      end else if (wr_ok && csr_addr_i == CSR_MSTATUS) begin
        gie_q <= csr_wdata_i[BIT_GIE];
        sie_q <= csr_wdata_i[BIT_SIE];
      end
      if (wr_ok) begin
        unique case (csr_addr_i)
          CSR_MIE:    mie_q    <= csr_wdata_i & IE_MASK;
          CSR_MTVEC:  mtvec_q  <= csr_wdata_i;
          CSR_MEPC:   mepc_q   <= csr_wdata_i & PC_MASK;
          CSR_MCAUSE: mcause_q <= csr_wdata_i & CAUSE_MASK;
          CSR_MTVAL:  mtval_q  <= csr_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_o   <= 1'b0;
      irq_cause_o <= '0;
    end else begin
      irq_req_o   <= sel_valid && !trap_valid_i;
      irq_cause_o <= CAUSE_W'(sel_idx);
    end
  end

  always_comb begin
    unique case (csr_addr_i)
      CSR_MSTATUS: csr_rdata_o = mstatus_rd;
      CSR_MIE:     csr_rdata_o = mie_q;
      CSR_MIP:     csr_rdata_o = mip_vec;
      CSR_MTVEC:   csr_rdata_o = mtvec_q;
      CSR_MEPC:    csr_rdata_o = mepc_q;
      CSR_MCAUSE:  csr_rdata_o = mcause_q & CAUSE_MASK;
      CSR_MTVAL:   csr_rdata_o = mtval_q;
      default:     csr_rdata_o = '0;
    endcase
  end

  assign vec_off = (mtvec_q[0] && trap_irq_i) ? (XLEN'(trap_cause_i) << 2) : '0;
  assign redirect_o = trap_valid_i || mret_i;
  assign redirect_pc_o = trap_valid_i ? ({mtvec_q[XLEN-1:2], 2'b00} + vec_off) : mepc_q;

  // R4
  trap_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (!gie_q && sie_q == $past(gie_q)));
  // R4
  mret_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_valid_i) |=> (sie_q && gie_q == $past(sie_q)));
  // R6
  exc_epc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !trap_irq_i) |=> mepc_q == ($past(trap_pc_i) & PC_MASK));
  // R5
  cause_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> mcause_q[XLEN-1] == $past(trap_irq_i));
  // R8
  trap_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |-> (redirect_o && redirect_pc_o[1:0] == 2'b00));
  // R10
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> !irq_req_o);
  // R2
  always_comb begin
    mpp_fixed_chk: assert (!rst_ni || mstatus_rd[12:11] == 2'b11);
  end
endmodule

// File: tb/test_m_trap_ctrl.sv
module test_m_trap_ctrl;
  localparam int XLEN = 32;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] priv = 2'b11;
  logic tv = 0, tirq = 0, mret = 0, sw = 0, tim = 0, ext = 0, we = 0;
  logic [CW-1:0] tcause = '0;
  logic [XLEN-1:0] tpc = '0, tnpc = '0, ttval = '0, taddr = '0, wdata = '0;
  logic [11:0] addr = '0;
  logic [XLEN-1:0] rdata, rpc;
  logic redir, ireq;
  logic [CW-1:0] icause;

  int tests = 0, fails = 0;
  bit m_gie, m_sie;
  logic [XLEN-1:0] m_ie, m_tvec, m_epc, m_cause, m_tval;

  always #5 clk = ~clk;

  m_trap_ctrl i_m_trap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv),
    .trap_valid_i(tv), .trap_irq_i(tirq), .trap_cause_i(tcause),
    .trap_pc_i(tpc), .trap_npc_i(tnpc), .trap_tval_i(ttval), .trap_addr_i(taddr),
    .mret_i(mret), .irq_sw_i(sw), .irq_tim_i(tim), .irq_ext_i(ext),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .redirect_o(redir), .redirect_pc_o(rpc), .irq_req_o(ireq), .irq_cause_o(icause)
  );

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_tval(int c, logic [XLEN-1:0] pc, logic [XLEN-1:0] tv_, logic [XLEN-1:0] ad);
    case (c)
      0: return tv_;
      2: return (tv_[1:0] != 2'b11) ? {16'h0, tv_[15:0]} : tv_;
      3: return pc;
      4, 6: return ad;
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_npc(logic [XLEN-1:0] tvec, bit irq, int c);
    return {tvec[XLEN-1:2], 2'b00} + ((tvec[0] && irq) ? XLEN'(c * 4) : '0);
  endfunction

  function automatic logic [XLEN-1:0] exp_mstatus();
    return 32'h1800 | (XLEN'(m_gie) << 3) | (XLEN'(m_sie) << 7);
  endfunction

  task automatic csr_rd(logic [11:0] a, logic [XLEN-1:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic csr_wr(logic [11:0] a, logic [XLEN-1:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 0;
    case (a)
      12'h300: begin m_gie = d[3]; m_sie = d[7]; end
      12'h304: m_ie = d & 32'h888;
      12'h305: m_tvec = d;
      12'h341: m_epc = d & ~32'h1;
      12'h342: m_cause = d & 32'h8000_000F;
      12'h343: m_tval = d;
      default: ;
    endcase
  endtask

  task automatic do_trap(bit irq, int c, logic [XLEN-1:0] pc, logic [XLEN-1:0] npc,
                         logic [XLEN-1:0] tval, logic [XLEN-1:0] ad, bit with_mret);
    @(negedge clk);
    tv = 1; tirq = irq; tcause = CW'(c); tpc = pc; tnpc = npc; ttval = tval; taddr = ad; mret = with_mret;
    #1;
    check("R8 redirect valid", XLEN'(redir), 1);
    check("R8 trap target", rpc, exp_npc(m_tvec, irq, c));
    @(posedge clk);
    #1 tv = 0; mret = 0;
    m_sie = m_gie; m_gie = 0;
    m_epc = (irq ? npc : pc) & ~32'h1;
    m_cause = {irq, 27'h0, 4'(c)};
    if (!irq) m_tval = exp_tval(c, pc, tval, ad);
    check("R10 no request after trap", XLEN'(ireq), 0);
  endtask

  task automatic do_mret();
    @(negedge clk);
    mret = 1;
    #1;
    check("R9 mret redirect", XLEN'(redir), 1);
    check("R9 mret target", rpc, m_epc);
    @(posedge clk);
    #1 mret = 0;
    m_gie = m_sie; m_sie = 1;
  endtask

  task automatic irq_chk();
    logic [XLEN-1:0] act_v;
    bit en;
    int exp_c;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    act_v = {20'h0, ext, 3'b0, tim, 3'b0, sw, 3'b0} & m_ie;
    en = (priv != 2'b11) || m_gie;
    if (!en) act_v = '0;
    exp_c = act_v[3] ? 3 : act_v[7] ? 7 : 11;
    check("R10 irq request", XLEN'(ireq), XLEN'(act_v != 0));
    if (act_v != 0) check("R10 irq priority", XLEN'(icause), XLEN'(exp_c));
  endtask

  task automatic check_all();
    csr_rd(12'h300, exp_mstatus(), "R2 mstatus");
    csr_rd(12'h304, m_ie, "R3 mie");
    csr_rd(12'h341, m_epc, "R6 mepc");
    csr_rd(12'h342, m_cause, "R5 mcause");
    csr_rd(12'h343, m_tval, "R7 mtval");
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int exc_set[7] = '{0, 2, 3, 4, 5, 6, 11};
    void'($urandom(32'h1234));
    m_gie = 0; m_sie = 0; m_ie = 0; m_tvec = 0; m_epc = 0; m_cause = 0; m_tval = 0;
    #23 rst_n = 1;
    // R1 reset values
    #1;
    check("R1 redirect", XLEN'(redir), 0);
    check("R1 irq", XLEN'(ireq), 0);
    csr_rd(12'h300, 32'h1800, "R1 mstatus");
    csr_rd(12'h305, 0, "R1 mtvec");
    check_all();

    // R2 all-ones write
    csr_wr(12'h300, '1);
    csr_rd(12'h300, 32'h1888, "R2 mstatus ones");
    csr_wr(12'h300, 0);
    csr_rd(12'h300, 32'h1800, "R2 mstatus zeros");

    // R3 mie mask and mip ignores writes
    csr_wr(12'h304, '1);
    csr_rd(12'h304, 32'h888, "R3 mie ones");
    sw = 0; tim = 1; ext = 0;
    csr_wr(12'h344, '1);
    csr_rd(12'h344, 32'h080, "R3 mip ignores write");

    // R10 all pending, enables, priv below machine
    sw = 1; tim = 1; ext = 1;
    irq_chk();
    csr_wr(12'h300, 32'h8);
    irq_chk();
    csr_wr(12'h304, 32'h880);
    irq_chk();
    csr_wr(12'h300, 0);
    priv = 2'b00;
    irq_chk();
    priv = 2'b11;
    irq_chk();

    // R5 mcause mask
    csr_wr(12'h342, '1);
    csr_rd(12'h342, 32'h8000_000F, "R5 mcause mask");

    // R7 compressed truncation corner
    csr_wr(12'h305, 32'h1001);
    do_trap(0, 2, 32'h100, 32'h102, 32'hABCD_0001, 0, 0);
    csr_rd(12'h343, 32'h0000_0001, "R7 cause2 short");
    do_trap(0, 2, 32'h100, 32'h104, 32'hABCD_0003, 0, 0);
    csr_rd(12'h343, 32'hABCD_0003, "R7 cause2 full");
    // R5 environment call
    do_trap(0, 11, 32'h200, 32'h204, 0, 0, 0);
    csr_rd(12'h342, 32'd11, "R5 ecall");
    // R8 vectored interrupt
    do_trap(1, 7, 32'h300, 32'h304, 0, 0, 0);
    csr_rd(12'h341, 32'h304, "R6 irq epc");
    // R4 trap beats mret
    csr_wr(12'h300, 32'h8);
    do_trap(0, 4, 32'h400, 32'h404, 0, 32'h777, 1);
    csr_rd(12'h300, exp_mstatus(), "R4 trap over mret");
    do_mret();
    csr_rd(12'h300, 32'h1888, "R4 mret pop");

    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 5);
      sw = 1'($urandom); tim = 1'($urandom); ext = 1'($urandom);
      priv = ($urandom_range(0, 3) == 0) ? 2'b00 : 2'b11;
      case (op)
        0: csr_wr(12'h300, $urandom);
        1: csr_wr(12'h304, $urandom);
        2: csr_wr(12'h305, $urandom);
        3: begin
          int c = exc_set[$urandom_range(0, 6)];
          do_trap(0, c, $urandom, $urandom, $urandom, $urandom, 0);
        end
        4: do_trap(1, $urandom_range(0, 15), $urandom, $urandom, $urandom, $urandom, 0);
        default: begin
          if ($urandom_range(0, 1) == 0) csr_wr(12'h341, $urandom);
          do_mret();
        end
      endcase
      check_all();
      irq_chk();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule